// File: doc/BRIEF.md
# Block Copy Engine with Completion Interrupt

This engine copies a contiguous block of bytes from one memory region to another in wide beats. A typical job is moving an input image into an accelerator's local activation memory, or moving a result vector back out. Software programs a source address, a destination address and a byte count through a small register window. It then sets a start bit.

The engine reads one beat from a synchronous source memory with one cycle of latency and writes it to the destination one cycle later. Latency is fixed: two setup cycles, then one cycle per beat. When the last beat is written, a sticky done flag is set. A level interrupt line follows that flag while interrupts are enabled. Software clears the flag by writing 1 to it.

Top module: `blk_dma`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `rd_en` and `wr_en` are low.
- R2: The register window is as follows. Offset 0x00 holds the source address and 0x04 the destination address. Offset 0x08 holds the byte count (LEN_W bits). At 0x0C, bit0 is start, which always reads 0, and bit1 is the interrupt enable. At 0x10, bit0 is busy and bit1 is done. Any other offset reads 0.
- R3: A start write is accepted only when the engine is idle. After that edge, status busy reads 1 for exactly 2 + ceil(len/64) cycles. The engine then reads done = 1.
- R4: Beat k (counting from 0) is read in cycle k+2 after the start edge, with `rd_addr` = source + 64·k.
- R5: Beat k is written in cycle k+3 after the start edge. In that cycle `wr_addr` = destination + 64·k and `wr_data` carries the data the source memory returned for beat k.
- R6: `wr_be` has all 64 bits set, except on the last beat of a count that is not a multiple of 64. On that beat only the low (len mod 64) bits are set.
- R7: A zero byte count issues no reads and no writes, and reads done after 2 busy cycles.
- R8: While busy, a further start is ignored. Writes to source, destination and count are also ignored, and read-back still shows the accepted values.
- R9: Done stays set until software writes 1 to status bit1. Writing 0 there has no effect.
- R10: `irq` is high exactly when done is set and the interrupt enable is 1. Changing the enable while done is set takes effect on the next cycle.
- R11: The low 6 bits of the source and destination addresses are ignored by the beat addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Level completion interrupt |
| rd_en | output | 1 | Source beat read request |
| rd_addr | output | ADDR_W | Source beat byte address |
| rd_data | input | BEAT_BYTES·8 | Source data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Destination beat write |
| wr_addr | output | ADDR_W | Destination beat byte address |
| wr_data | output | BEAT_BYTES·8 | Destination beat data |
| wr_be | output | BEAT_BYTES | Destination byte enables |

## Verification
Cycles are counted from the clock edge that accepts the start write. The bench keeps a cycle index that it advances on each falling edge during a transfer.

- The read of beat k must appear at index k+2 and its write at index k+3.
- Busy must read 1 on exactly 2 + ceil(len/64) falling-edge samples.
- Done and `irq` must already be visible on the first sample where busy reads 0.

Every beat is compared against an address-derived data pattern and a byte-mask formula. Byte counts are swept from 0 to 320 in steps of 7, together with the 63/64/65 and 1024 edges.

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [4:0]              cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic [31:0]             cfg_rdata,
  output logic                    irq,
  output logic                    rd_en,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic [BEAT_BYTES*8-1:0] rd_data,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [BEAT_BYTES*8-1:0] wr_data,
  output logic [BEAT_BYTES-1:0]   wr_be
);
  localparam int OFS_W = $clog2(BEAT_BYTES);
  localparam int ABW   = ADDR_W - OFS_W;
  localparam int CNT_W = LEN_W - OFS_W + 2;
  localparam logic [4:0] A_SRC = 5'h00, A_DST = 5'h04, A_LEN = 5'h08,
                         A_CTL = 5'h0C, A_STA = 5'h10;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              ie_q, busy_q, done_q;
  logic [CNT_W-1:0]  cyc_q;

  logic [CNT_W-1:0]  beats, rd_idx, wr_idx;
  logic [OFS_W-1:0]  rem;
  logic              cfg_open, go, clr_done, finish;

  assign rem    = len_q[OFS_W-1:0];
  assign beats  = CNT_W'(len_q[LEN_W-1:OFS_W]) + CNT_W'(|rem);
  assign rd_idx = cyc_q - CNT_W'(1);
  assign wr_idx = cyc_q - CNT_W'(2);

  assign cfg_open = cfg_we && !busy_q;
  assign go       = cfg_open && cfg_addr == A_CTL && cfg_wdata[0];
  assign clr_done = cfg_we && cfg_addr == A_STA && cfg_wdata[1];
  assign finish   = busy_q && cyc_q == beats + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_q <= '0; len_q <= '0; ie_q <= 1'b0;
    end else begin
      if (cfg_open && cfg_addr == A_SRC) src_q <= cfg_wdata[ADDR_W-1:0];
      if (cfg_open && cfg_addr == A_DST) dst_q <= cfg_wdata[ADDR_W-1:0];
      if (cfg_open && cfg_addr == A_LEN) len_q <= cfg_wdata[LEN_W-1:0];
      if (cfg_we && cfg_addr == A_CTL)   ie_q  <= cfg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; cyc_q <= '0;
    end else begin
      if (go) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cyc_q <= cyc_q + CNT_W'(1);
      end
      if (finish)        done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  assign rd_en   = busy_q && cyc_q != '0 && rd_idx < beats;
  assign rd_addr = {src_q[ADDR_W-1:OFS_W] + ABW'(rd_idx), {OFS_W{1'b0}}};

  assign wr_en   = busy_q && cyc_q >= CNT_W'(2);
  assign wr_addr = {dst_q[ADDR_W-1:OFS_W] + ABW'(wr_idx), {OFS_W{1'b0}}};
  assign wr_data = rd_data;
  assign wr_be   = (wr_idx == beats - CNT_W'(1) && rem != '0)
                   ? ~({BEAT_BYTES{1'b1}} << rem) : {BEAT_BYTES{1'b1}};

  assign irq = done_q && ie_q;

  always_comb begin
    case (cfg_addr)
      A_SRC:   cfg_rdata = 32'(src_q);
      A_DST:   cfg_rdata = 32'(dst_q);
      A_LEN:   cfg_rdata = 32'(len_q);
      A_CTL:   cfg_rdata = {30'd0, ie_q, 1'b0};
      A_STA:   cfg_rdata = {30'd0, done_q, busy_q};
      default: cfg_rdata = '0;
    endcase
  end

  p_setup_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !rd_en && !wr_en);
  p_end_sets_done_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  p_write_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en));
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(src_q) && $stable(dst_q) && $stable(len_q));
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    done_q && !clr_done |=> done_q);
endmodule

// File: tb/blk_dma_bench.sv
`timescale 1ns/1ps
module blk_dma_bench;
  localparam int AW = 32, LW = 16, BB = 64, DW = BB * 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic irq, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data = '0, wr_data;
  logic [BB-1:0] wr_be;

  always #2.5 clk = ~clk;

  blk_dma #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB)) u_blk_dma (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata, .irq,
    .rd_en, .rd_addr, .rd_data, .wr_en, .wr_addr, .wr_data, .wr_be);

  int n_chk = 0, n_bad = 0;
  int tcyc = 0, rd_seen = 0, wr_seen = 0;
  bit in_xfer = 0;
  logic [31:0] e_src, e_dst;
  int e_len;

  function automatic logic [DW-1:0] pat(input logic [31:0] a);
    logic [DW-1:0] r;
    for (int i = 0; i < BB / 4; i++) r[i*32 +: 32] = (a ^ 32'h5A5A0000) + 32'(i) * 32'h11111111;
    return r;
  endfunction

  function automatic logic [BB-1:0] exp_be(input int len, input int k);
    int nb = (len + BB - 1) / BB;
    int rm = len % BB;
    logic [BB-1:0] m = '1;
    if (k == nb - 1 && rm != 0)
      for (int i = 0; i < BB; i++) m[i] = (i < rm);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

  always @(negedge clk) begin
    if (in_xfer) tcyc++;
    if (rd_en) begin
      chk(in_xfer && tcyc == rd_seen + 2, "R4 read cycle", DW'(tcyc), DW'(rd_seen + 2));
      chk(rd_addr == e_src + 32'(64 * rd_seen), "R4 R11 read addr", DW'(rd_addr), DW'(e_src + 32'(64 * rd_seen)));
      rd_seen++;
    end
    if (wr_en) begin
      chk(in_xfer && tcyc == wr_seen + 3, "R5 write cycle", DW'(tcyc), DW'(wr_seen + 3));
      chk(wr_addr == e_dst + 32'(64 * wr_seen), "R5 R11 write addr", DW'(wr_addr), DW'(e_dst + 32'(64 * wr_seen)));
      chk(wr_data == pat(e_src + 32'(64 * wr_seen)), "R5 write data", wr_data, pat(e_src + 32'(64 * wr_seen)));
      chk(wr_be == exp_be(e_len, wr_seen), "R6 byte enables", DW'(wr_be), DW'(exp_be(e_len, wr_seen)));
      wr_seen++;
    end
  end

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #0.5 cfg_we = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #0.5 d = cfg_rdata;
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input int len, input bit ie);
    wreg(5'h00, s); wreg(5'h04, d); wreg(5'h08, 32'(len));
    e_src = s & ~32'h3F; e_dst = d & ~32'h3F; e_len = len;
    rd_seen = 0; wr_seen = 0;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 5'h0C; cfg_wdata = {30'd0, ie, 1'b1};
    @(posedge clk); tcyc = 0; in_xfer = 1;
    #0.5 cfg_we = 1'b0; cfg_addr = 5'h10;
  endtask

  task automatic wait_idle(output int first_idle);
    logic [31:0] st;
    first_idle = -1;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk); cfg_addr = 5'h10; #0.5 st = cfg_rdata;
      if (!st[0]) begin first_idle = tcyc; break; end
    end
    in_xfer = 0;
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] d, input int len, input bit ie);
    int fi, nb;
    logic [31:0] st;
    nb = (len + BB - 1) / BB;
    launch(s, d, len, ie);
    wait_idle(fi);
    chk(fi == nb + 3, "R3 busy length", DW'(fi - 1), DW'(nb + 2));
    chk(rd_seen == nb && wr_seen == nb, "R3 R7 beat count", DW'(wr_seen), DW'(nb));
    #0.5 st = cfg_rdata;
    chk(st[1] == 1'b1, "R3 done after busy", DW'(st), 2);
    chk(irq == ie, "R10 irq follows enable", DW'(irq), DW'(ie));
    wreg(5'h10, 32'h2);
    rreg(5'h10, st);
    chk(st == 0 && irq == 0, "R9 clear done", DW'(st), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int fi;
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;
    for (int a = 0; a <= 5'h14; a += 4) begin
      rreg(5'(a), v);
      chk(v == 0, "R1 reset register", DW'(v), 0);
    end
    chk(!irq && !rd_en && !wr_en, "R1 reset outputs", DW'({irq, rd_en, wr_en}), 0);

    wreg(5'h00, 32'hDEAD_BE40); wreg(5'h04, 32'h1234_5680); wreg(5'h08, 32'h0001_0123);
    rreg(5'h00, v); chk(v == 32'hDEAD_BE40, "R2 src readback", DW'(v), DW'(32'hDEAD_BE40));
    rreg(5'h04, v); chk(v == 32'h1234_5680, "R2 dst readback", DW'(v), DW'(32'h1234_5680));
    rreg(5'h08, v); chk(v == 32'h0000_0123, "R2 len readback", DW'(v), DW'(32'h123));
    wreg(5'h0C, 32'h2);
    rreg(5'h0C, v); chk(v == 32'h2, "R2 ctrl readback", DW'(v), 2);
    rreg(5'h14, v); chk(v == 0, "R2 unmapped", DW'(v), 0);
    wreg(5'h0C, 32'h0);

    run(32'h0000_1000, 32'h8000_0000, 0, 1);
    for (int len = 1; len <= 320; len += 7)
      run(32'h0001_0000 + 32'(len * 256), 32'h0040_0000 + 32'(len * 128), len, len[0]);
    run(32'h0002_0000, 32'h0003_0000, 63, 1);
    run(32'h0002_0000, 32'h0003_0000, 64, 1);
    run(32'h0002_0000, 32'h0003_0000, 65, 0);
    run(32'h1000_0025, 32'h2000_003F, 1024, 1);

    launch(32'h0005_0000, 32'h0006_0000, 1024, 1);
    wreg(5'h00, 32'hFFFF_0000);
    wreg(5'h08, 32'd5);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 5'h0C; cfg_wdata = 32'h3;
    @(posedge clk); #0.5 cfg_we = 1'b0;
    wait_idle(fi);
    chk(fi == 19, "R8 restart ignored", DW'(fi - 1), 18);
    chk(wr_seen == 16, "R8 beats unchanged", DW'(wr_seen), 16);
    rreg(5'h00, v); chk(v == 32'h0005_0000, "R8 src frozen", DW'(v), DW'(32'h0005_0000));
    rreg(5'h08, v); chk(v == 1024, "R8 len frozen", DW'(v), 1024);

    repeat (5) @(posedge clk);
    rreg(5'h10, v); chk(v == 2 && irq, "R9 done holds", DW'(v), 2);
    wreg(5'h10, 32'h0);
    rreg(5'h10, v); chk(v == 2, "R9 write zero no effect", DW'(v), 2);
    wreg(5'h0C, 32'h0);
    @(negedge clk); chk(!irq, "R10 irq masked", DW'(irq), 0);
    wreg(5'h0C, 32'h2);
    @(negedge clk); chk(irq, "R10 irq unmasked", DW'(irq), 1);
    wreg(5'h10, 32'h2);
    @(negedge clk); chk(!irq, "R9 irq cleared", DW'(irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule